// File: doc/BRIEF.md
# Unlock-Sequence Command Interface

This block sits between a byte-wide host write bus and the embedded program/erase engine of a flash array. Each host write arrives as one strobe cycle carrying an address and a data byte. The block checks the two-write unlock key, follows the multi-write instruction sequences, and emits one single-clock instruction pulse. Each pulse carries an operation code together with the address and data of the write that completed the instruction. Any write that breaks a sequence sends the block back to idle, and the read path falls back to plain array reads.

The block also decides what a host read returns. It reports whether reads should come from the array, from the identification space, or from the engine's status bits. While the identification space is selected, it drives the identification byte chosen by the two low read-address bits. The engine reports its own condition through four flags: algorithm active, erase window open, erase running and erase suspended. The block uses these flags to filter writes while an erase is in progress and to accept suspend, resume and extra block addresses.

Top module: `flash_cmd_if`

## Requirements
- R1: The unlock key is data AAh at address 555h, then data 55h at address AAAh. Only the low 12 address bits are compared, and the bits above them are ignored.
- R2: After the key, a write of A0h at 555h arms a program. The next write, whatever its data (including F0h), produces a PROGRAM pulse carrying that write's address and data.
- R3: After the key, a write of 80h at 555h, and then the key a second time, the final write decides the erase. 30h at any address produces BLK_ERASE. 10h at 555h produces CHIP_ERASE.
- R4: After the key, a write of 90h at 555h produces AUTOSEL and selects signature mode. In that mode `id_data` shows 20h for rd_sel=00, the device code for 01, 01h/00h for 10 (block protected / not protected), and 00h for 11. Outside signature mode `id_data` is 00h.
- R5: A write of F0h produces a RESET pulse, returns the sequence to idle and selects array mode. This holds in any sequence state except the armed program cycle.
- R6: A write that does not match the expected step aborts the sequence. No pulse is issued, the sequence returns to idle and array mode is selected. The same applies to a write in idle that starts nothing.
- R7: A pulse appears on `cmd_valid` for exactly the one clock after the completing write edge. `cmd_op` is encoded as RESET=0, AUTOSEL=1, PROGRAM=2, BLK_ERASE=3, CHIP_ERASE=4, SUSPEND=5, RESUME=6. Every pulse returns the sequence to idle. No write means no pulse.
- R8: While `erase_open` or `erase_run` is high, only three writes are acted on. B0h gives SUSPEND. F0h gives RESET. 30h gives BLK_ERASE (an added block), but only while `erase_open` is high. Every other write is ignored and leaves the sequence state untouched.
- R9: With no erase window or erase running, a 30h write in idle gives RESUME while `erase_susp` is high. The same write aborts (R6) while `erase_susp` is low.
- R10: `rd_mode` is registered and encoded ARRAY=0, SIG=1, STATUS=2. It shows STATUS in the cycle after `pe_busy` was sampled high, and otherwise the mode selected by the sequence.
- R11: After reset the sequence is idle, `cmd_valid` is low, `rd_mode` is ARRAY and `id_data` is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe, one cycle per bus write |
| wr_addr | input | ADDR_W | Host write address |
| wr_data | input | 8 | Host write data / command byte |
| pe_busy | input | 1 | Engine algorithm active; reads return status |
| erase_open | input | 1 | Erase start window open; more blocks may be added |
| erase_run | input | 1 | Erase algorithm running |
| erase_susp | input | 1 | Erase currently suspended |
| rd_sel | input | 2 | Low read-address bits selecting the identification byte |
| blk_prot | input | 1 | Protection state of the block addressed by the read |
| cmd_valid | output | 1 | One-clock instruction pulse |
| cmd_op | output | 3 | Instruction code |
| cmd_addr | output | ADDR_W | Address of the completing write |
| cmd_data | output | 8 | Data of the completing write |
| rd_mode | output | 2 | Read source: array, signature or status |
| id_data | output | 8 | Identification byte in signature mode, else 00h |

## Verification
Two functions can land on the same edge. One is a write that completes or breaks a sequence. The other is a change of the engine flags, which selects the filtered erase behaviour and the status read mode. The bench provokes this with random flag levels drawn afresh on every write. The directed cases cover four situations: a sequence key followed by a filtered write under `erase_run`, then an accepted command once the flag has fallen; an added 30h block on an edge where `erase_open` is high; the same 30h with only `erase_susp` high; and an auto-select completing while `pe_busy` is high. For each write, a bench model predicts the pulse, the mode and the identification byte from the flag levels sampled at that edge, and the model is compared with the ports one clock later.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    OP_RESET      = 3'd0,
    OP_AUTOSEL    = 3'd1,
    OP_PROGRAM    = 3'd2,
    OP_BLK_ERASE  = 3'd3,
    OP_CHIP_ERASE = 3'd4,
    OP_SUSPEND    = 3'd5,
    OP_RESUME     = 3'd6
  } op_e;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_SIG    = 2'd1,
    RM_STATUS = 2'd2
  } rmode_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_KEY1,
    SQ_KEY2,
    SQ_PGM,
    SQ_ERS1,
    SQ_ERS2,
    SQ_ERS3
  } seq_e;

  localparam logic [7:0] C_KEY1 = 8'hAA;
  localparam logic [7:0] C_KEY2 = 8'h55;
  localparam logic [7:0] C_PGM  = 8'hA0;
  localparam logic [7:0] C_ESET = 8'h80;
  localparam logic [7:0] C_ASEL = 8'h90;
  localparam logic [7:0] C_CHIP = 8'h10;
  localparam logic [7:0] C_BLK  = 8'h30;
  localparam logic [7:0] C_SUSP = 8'hB0;
  localparam logic [7:0] C_RST  = 8'hF0;

  typedef struct packed {
    logic key1;
    logic key2;
    logic pgm;
    logic eset;
    logic asel;
    logic chip;
    logic blk;
    logic susp;
    logic rst;
  } dec_t;

endpackage

// File: rtl/fci_decode.sv
module fci_decode
  import flash_cmd_pkg::*;
#(
  parameter int UNLK_W = 12
) (
  input  logic [UNLK_W-1:0] addr_lo,
  input  logic [7:0]        data,
  output dec_t              dec
);

  // Alternating key-address patterns: ...0101 and ...1010
  logic [UNLK_W-1:0] pat_lo;
  logic [UNLK_W-1:0] pat_hi;

  for (genvar i = 0; i < UNLK_W; i++) begin : g_pat
    assign pat_lo[i] = ((i % 2) == 0) ? 1'b1 : 1'b0;
    assign pat_hi[i] = ((i % 2) == 1) ? 1'b1 : 1'b0;
  end

  logic at_lo;
  logic at_hi;

  assign at_lo = (addr_lo == pat_lo);
  assign at_hi = (addr_lo == pat_hi);

  always_comb begin
    dec.key1 = at_lo && (data == C_KEY1);
    dec.key2 = at_hi && (data == C_KEY2);
    dec.pgm  = at_lo && (data == C_PGM);
    dec.eset = at_lo && (data == C_ESET);
    dec.asel = at_lo && (data == C_ASEL);
    dec.chip = at_lo && (data == C_CHIP);
    dec.blk  = (data == C_BLK);
    dec.susp = (data == C_SUSP);
    dec.rst  = (data == C_RST);
  end

endmodule

// File: rtl/fci_seq.sv
module fci_seq
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  dec_t              dec,
  input  logic              pe_busy,
  input  logic              erase_open,
  input  logic              erase_run,
  input  logic              erase_susp,
  output logic              cmd_valid,
  output logic [2:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [7:0]        cmd_data,
  output logic [1:0]        rd_mode,
  output rmode_e            mode_nx
);

  seq_e   st_q, st_d;
  rmode_e md_q;
  logic   fire;
  logic   adv;
  op_e    op;
  logic   win;

  assign win = erase_open | erase_run;

  always_comb begin
    st_d    = st_q;
    mode_nx = md_q;
    fire    = 1'b0;
    adv     = 1'b0;
    op      = OP_RESET;
    if (wr_en) begin
      if (win) begin
        // filtered: only suspend, reset and added blocks act
        if (dec.susp) begin
          fire = 1'b1; op = OP_SUSPEND;
        end else if (dec.rst) begin
          fire = 1'b1; op = OP_RESET;
        end else if (dec.blk && erase_open) begin
          fire = 1'b1; op = OP_BLK_ERASE;
        end
      end else if (st_q == SQ_PGM) begin
        fire = 1'b1; op = OP_PROGRAM;
      end else if (dec.rst) begin
        fire = 1'b1; op = OP_RESET;
      end else begin
        unique case (st_q)
          SQ_IDLE: begin
            if (dec.key1) begin
              st_d = SQ_KEY1; adv = 1'b1;
            end else if (dec.blk && erase_susp) begin
              fire = 1'b1; op = OP_RESUME;
            end
          end
          SQ_KEY1: if (dec.key2) begin st_d = SQ_KEY2; adv = 1'b1; end
          SQ_KEY2: begin
            if (dec.pgm) begin
              st_d = SQ_PGM; adv = 1'b1;
            end else if (dec.eset) begin
              st_d = SQ_ERS1; adv = 1'b1;
            end else if (dec.asel) begin
              fire = 1'b1; op = OP_AUTOSEL;
            end
          end
          SQ_ERS1: if (dec.key1) begin st_d = SQ_ERS2; adv = 1'b1; end
          SQ_ERS2: if (dec.key2) begin st_d = SQ_ERS3; adv = 1'b1; end
          SQ_ERS3: begin
            if (dec.blk) begin
              fire = 1'b1; op = OP_BLK_ERASE;
            end else if (dec.chip) begin
              fire = 1'b1; op = OP_CHIP_ERASE;
            end
          end
          default: adv = 1'b0;
        endcase
        if (!adv && !fire) begin
          st_d    = SQ_IDLE;
          mode_nx = RM_ARRAY;
        end
      end
      if (fire) begin
        st_d    = SQ_IDLE;
        mode_nx = (op == OP_AUTOSEL) ? RM_SIG : RM_ARRAY;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= SQ_IDLE;
      md_q      <= RM_ARRAY;
      cmd_valid <= 1'b0;
      cmd_op    <= OP_RESET;
      cmd_addr  <= '0;
      cmd_data  <= '0;
      rd_mode   <= RM_ARRAY;
    end else begin
      st_q      <= st_d;
      md_q      <= mode_nx;
      cmd_valid <= fire;
      if (fire) begin
        cmd_op   <= op;
        cmd_addr <= wr_addr;
        cmd_data <= wr_data;
      end
      rd_mode <= pe_busy ? RM_STATUS : mode_nx;
    end
  end

endmodule

// File: rtl/fci_idread.sv
module fci_idread #(
  parameter logic [7:0] MFR_CODE = 8'h20,
  parameter logic [7:0] DEV_CODE = 8'hB0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sig_en,
  input  logic [1:0] rd_sel,
  input  logic       blk_prot,
  output logic [7:0] id_data
);

  logic [7:0] code;

  always_comb begin
    unique case (rd_sel)
      2'b00:   code = MFR_CODE;
      2'b01:   code = DEV_CODE;
      2'b10:   code = {7'd0, blk_prot};
      default: code = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) id_data <= 8'h00;
    else     id_data <= sig_en ? code : 8'h00;
  end

endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
  import flash_cmd_pkg::*;
#(
  parameter int         ADDR_W   = 18,
  parameter int         UNLK_W   = 12,
  parameter logic [7:0] MFR_CODE = 8'h20,
  parameter logic [7:0] DEV_CODE = 8'hB0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              pe_busy,
  input  logic              erase_open,
  input  logic              erase_run,
  input  logic              erase_susp,
  input  logic [1:0]        rd_sel,
  input  logic              blk_prot,
  output logic              cmd_valid,
  output logic [2:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [7:0]        cmd_data,
  output logic [1:0]        rd_mode,
  output logic [7:0]        id_data
);

  dec_t   dec;
  rmode_e mode_nx;
  logic   sig_en;

  fci_decode #(.UNLK_W(UNLK_W)) u_dec (
    .addr_lo (wr_addr[UNLK_W-1:0]),
    .data    (wr_data),
    .dec     (dec)
  );

  fci_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .dec        (dec),
    .pe_busy    (pe_busy),
    .erase_open (erase_open),
    .erase_run  (erase_run),
    .erase_susp (erase_susp),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_addr   (cmd_addr),
    .cmd_data   (cmd_data),
    .rd_mode    (rd_mode),
    .mode_nx    (mode_nx)
  );

  assign sig_en = !pe_busy && (mode_nx == RM_SIG);

  fci_idread #(.MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_id (
    .clk      (clk),
    .rst      (rst),
    .sig_en   (sig_en),
    .rd_sel   (rd_sel),
    .blk_prot (blk_prot),
    .id_data  (id_data)
  );

endmodule

// File: rtl/fci_chk.sv
module fci_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              pe_busy,
  input logic              erase_open,
  input logic              erase_run,
  input logic              cmd_valid,
  input logic [2:0]        cmd_op,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [7:0]        cmd_data,
  input logic [1:0]        rd_mode,
  input logic [7:0]        id_data
);

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> !cmd_valid); // R7

  AST_PULSE_FIELDS: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (!cmd_valid || (cmd_addr == $past(wr_addr) && cmd_data == $past(wr_data)))); // R7

  AST_SUSPEND_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (erase_open || erase_run) && wr_data == 8'hB0) |=> (cmd_valid && cmd_op == 3'd5)); // R8

  AST_FILTERED_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (erase_open || erase_run) && wr_data != 8'hB0 && wr_data != 8'hF0 && wr_data != 8'h30)
      |=> !cmd_valid); // R8

  AST_RESET_IN_ERASE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (erase_open || erase_run) && wr_data == 8'hF0) |=> (cmd_valid && cmd_op == 3'd0)); // R5

  AST_STATUS_MODE: assert property (@(posedge clk) disable iff (rst)
    pe_busy |=> rd_mode == 2'd2); // R10

  AST_ID_QUIET: assert property (@(posedge clk) disable iff (rst)
    (rd_mode != 2'd1) |-> id_data == 8'h00); // R4

endmodule

bind flash_cmd_if fci_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .pe_busy    (pe_busy),
  .erase_open (erase_open),
  .erase_run  (erase_run),
  .cmd_valid  (cmd_valid),
  .cmd_op     (cmd_op),
  .cmd_addr   (cmd_addr),
  .cmd_data   (cmd_data),
  .rd_mode    (rd_mode),
  .id_data    (id_data)
);

// File: tb/sim_flash_cmd_if.sv
module sim_flash_cmd_if;

  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = 8'h00;
  logic          pe_busy = 1'b0;
  logic          erase_open = 1'b0;
  logic          erase_run = 1'b0;
  logic          erase_susp = 1'b0;
  logic [1:0]    rd_sel = 2'b00;
  logic          blk_prot = 1'b0;
  logic          cmd_valid;
  logic [2:0]    cmd_op;
  logic [AW-1:0] cmd_addr;
  logic [7:0]    cmd_data;
  logic [1:0]    rd_mode;
  logic [7:0]    id_data;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // bench reference state
  int       m_st = 0;
  int       m_md = 0;
  bit       e_valid = 0;
  int       e_op = 0;
  logic [AW-1:0] e_addr = '0;
  logic [7:0]    e_data = 8'h00;
  int       e_mode = 0;
  logic [7:0]    e_id = 8'h00;

  always #10 clk = ~clk;  // 50 MHz

  flash_cmd_if #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pe_busy(pe_busy), .erase_open(erase_open), .erase_run(erase_run),
    .erase_susp(erase_susp), .rd_sel(rd_sel), .blk_prot(blk_prot),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .rd_mode(rd_mode), .id_data(id_data)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] id_code(input logic [1:0] s, input logic p);
    case (s)
      2'b00:   return 8'h20;
      2'b01:   return 8'hB0;
      2'b10:   return {7'd0, p};
      default: return 8'h00;
    endcase
  endfunction

  // one bus cycle: drive at negedge, model at posedge, compare at next negedge
  task automatic step(input bit we, input logic [AW-1:0] a, input logic [7:0] d, input string tag);
    bit f;
    bit adv;
    bit a5;
    bit aa;
    int op;
    wr_en = we; wr_addr = a; wr_data = d;
    @(posedge clk);
    f = 0; adv = 0; op = 0;
    a5 = (a[11:0] == 12'h555);
    aa = (a[11:0] == 12'hAAA);
    if (we) begin
      if (erase_open || erase_run) begin
        if (d == 8'hB0) begin f = 1; op = 5; end
        else if (d == 8'hF0) begin f = 1; op = 0; end
        else if (d == 8'h30 && erase_open) begin f = 1; op = 3; end
      end else if (m_st == 3) begin
        f = 1; op = 2;
      end else if (d == 8'hF0) begin
        f = 1; op = 0;
      end else begin
        case (m_st)
          0: if (a5 && d == 8'hAA) begin m_st = 1; adv = 1; end
             else if (d == 8'h30 && erase_susp) begin f = 1; op = 6; end
          1: if (aa && d == 8'h55) begin m_st = 2; adv = 1; end
          2: if (a5 && d == 8'hA0) begin m_st = 3; adv = 1; end
             else if (a5 && d == 8'h80) begin m_st = 4; adv = 1; end
             else if (a5 && d == 8'h90) begin f = 1; op = 1; end
          4: if (a5 && d == 8'hAA) begin m_st = 5; adv = 1; end
          5: if (aa && d == 8'h55) begin m_st = 6; adv = 1; end
          6: if (d == 8'h30) begin f = 1; op = 3; end
             else if (a5 && d == 8'h10) begin f = 1; op = 4; end
          default: ;
        endcase
        if (!adv && !f) begin m_st = 0; m_md = 0; end
      end
      if (f) begin m_st = 0; m_md = (op == 1) ? 1 : 0; end
    end
    e_valid = f;
    if (f) begin e_op = op; e_addr = a; e_data = d; end
    e_mode = pe_busy ? 2 : m_md;
    e_id   = (!pe_busy && m_md == 1) ? id_code(rd_sel, blk_prot) : 8'h00;
    @(negedge clk);
    chk(tag, "cmd_valid", int'(cmd_valid), int'(e_valid));
    if (e_valid) begin
      chk(tag, "cmd_op", int'(cmd_op), e_op);
      chk(tag, "cmd_addr", int'(cmd_addr), int'(e_addr));
      chk(tag, "cmd_data", int'(cmd_data), int'(e_data));
    end
    chk(tag, "rd_mode", int'(rd_mode), e_mode);
    chk(tag, "id_data", int'(id_data), int'(e_id));
  endtask

  task automatic idle(input string tag);
    step(0, '0, 8'h00, tag);
  endtask

  task automatic unlock(input string tag);
    step(1, 18'h00555, 8'hAA, tag);
    step(1, 18'h00AAA, 8'h55, tag);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11: reset state
    @(negedge clk);
    chk("R11", "cmd_valid", int'(cmd_valid), 0);
    chk("R11", "rd_mode", int'(rd_mode), 0);
    chk("R11", "id_data", int'(id_data), 0);

    // R1/R4: auto-select with junk upper address bits
    step(1, 18'h3F555, 8'hAA, "R1");
    step(1, 18'h2CAAA, 8'h55, "R1");
    step(1, 18'h15555, 8'h90, "R4");
    rd_sel = 2'b00; idle("R4");
    rd_sel = 2'b01; idle("R4");
    rd_sel = 2'b10; blk_prot = 1'b1; idle("R4");
    blk_prot = 1'b0; idle("R4");
    rd_sel = 2'b11; idle("R4");
    rd_sel = 2'b00;
    // R10: status overrides signature while busy
    pe_busy = 1'b1; idle("R10");
    pe_busy = 1'b0; idle("R10");
    // R5: reset returns to array
    step(1, 18'h12345, 8'hF0, "R5");

    // R2: program, data F0h is still program data
    unlock("R2");
    step(1, 18'h00555, 8'hA0, "R2");
    step(1, 18'h1ABCD, 8'hF0, "R2");

    // R3: block erase then chip erase
    unlock("R3");
    step(1, 18'h00555, 8'h80, "R3");
    unlock("R3");
    step(1, 18'h2B123, 8'h30, "R3");
    unlock("R3");
    step(1, 18'h00555, 8'h80, "R3");
    unlock("R3");
    step(1, 18'h00555, 8'h10, "R3");
    // R6: chip code at wrong address aborts
    unlock("R6");
    step(1, 18'h00555, 8'h80, "R6");
    unlock("R6");
    step(1, 18'h00556, 8'h10, "R6");

    // R6: broken key then stray command
    rd_sel = 2'b01;
    unlock("R6");
    step(1, 18'h00555, 8'h90, "R6");
    step(1, 18'h00555, 8'hAA, "R6");
    step(1, 18'h00555, 8'h55, "R6");
    step(1, 18'h00555, 8'h90, "R6");

    // R5: reset in the middle of a sequence
    unlock("R5");
    step(1, 18'h00777, 8'hF0, "R5");

    // R8: filtered write keeps the sequence state
    unlock("R8");
    erase_run = 1'b1;
    step(1, 18'h00555, 8'h12, "R8");
    step(1, 18'h00555, 8'hAA, "R8");
    erase_run = 1'b0;
    step(1, 18'h00555, 8'h90, "R8");
    erase_run = 1'b1;
    step(1, 18'h01000, 8'hB0, "R8");
    erase_run = 1'b0; erase_open = 1'b1;
    step(1, 18'h31000, 8'h30, "R8");
    step(1, 18'h00000, 8'hF0, "R8");
    erase_open = 1'b0; erase_run = 1'b1;
    step(1, 18'h31000, 8'h30, "R8");
    erase_run = 1'b0;

    // R9: resume only while suspended
    erase_susp = 1'b1;
    step(1, 18'h20000, 8'h30, "R9");
    erase_susp = 1'b0;
    step(1, 18'h20000, 8'h30, "R9");

    // R10: auto-select completing while busy
    unlock("R10");
    pe_busy = 1'b1;
    step(1, 18'h00555, 8'h90, "R10");
    pe_busy = 1'b0;
    idle("R10");
    step(1, 18'h0, 8'hF0, "R5");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int k;
      logic [AW-1:0] a;
      logic [7:0] d;
      bit we;
      erase_open = ($urandom % 10) == 0;
      erase_run  = ($urandom % 10) == 0;
      erase_susp = ($urandom % 6) == 0;
      pe_busy    = ($urandom % 8) == 0;
      rd_sel     = 2'($urandom);
      blk_prot   = 1'($urandom);
      k  = int'($urandom % 13);
      we = 1;
      a  = {6'($urandom), 12'h555};
      case (k)
        0, 1: d = 8'hAA;
        2: begin d = 8'h55; a[11:0] = 12'hAAA; end
        3: begin d = 8'h55; a[11:0] = (($urandom % 4) == 0) ? 12'h555 : 12'hAAA; end
        4: d = 8'hA0;
        5: d = 8'h80;
        6: d = 8'h90;
        7: d = 8'h10;
        8: begin d = 8'h30; a = 18'($urandom); end
        9: begin d = 8'hF0; a = 18'($urandom); end
        10: begin d = 8'hB0; a = 18'($urandom); end
        11: begin d = 8'($urandom); a = 18'($urandom); end
        default: begin we = 0; d = 8'h00; end
      endcase
      step(we, a, d, "R7");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule